// File: doc/BRIEF.md
# Conversion Window Comparator

This block watches the stream of finished analog-to-digital conversion results and decides, for each one, whether it falls in a region of interest set by two shared 16-bit thresholds: a "greater-than" bound and a "less-than" bound. Each result arrives with a valid strobe, a tag naming its source (single-channel or scan), a flag saying whether it is differential or single-ended, and a resolution code. The block first widens the result to 16 bits. Differential results are sign-extended and single-ended results are zero-padded. It then compares the widened value with the thresholds.

The ordering of the two thresholds picks the kind of test. If the less-than bound is above the greater-than bound, a hit means the sample lies strictly inside the window. In every other case, a hit means the sample lies strictly outside it. Each source has its own compare enable. A hit from an enabled source raises a one-cycle pulse and sets a sticky flag for that source. Software clears the sticky flag with a write-1-to-clear input.

Top module: `conv_window_cmp`

## Requirements
- R1: After synchronous reset, both sticky flags and both pulses are 0, and both thresholds are 0. With thresholds at 0, a single-ended 0 gives no hit and a single-ended 1 gives a hit.
- R2: A single-ended result is zero-padded above its resolution, and data bits above the resolution are ignored. The `res_mode` code is 0 for 12 bits, 1 for 8 bits, 2 for 6 bits and 3 for the full 16 bits.
- R3: A differential result is sign-extended from the top bit of its resolution, using the same `res_mode` codes.
- R4: With `res_mode` = 3, all 16 bits of `res_data` are compared as they are, with no extension or masking.
- R5: When the less-than threshold is greater than the greater-than threshold, a hit requires sample > greater-than AND sample < less-than (both strict).
- R6: When the less-than threshold is not greater than the greater-than threshold, a hit requires sample > greater-than OR sample < less-than (both strict). Equal thresholds select this mode.
- R7: For differential results the sample, both thresholds and the threshold ordering are read as two's-complement signed values. For single-ended results they are read as unsigned.
- R8: `cmp_pulse[s]` is high for exactly the one cycle after the clock edge that samples a hitting result from source s. Bit 0 is single, bit 1 is scan, and `res_src` = 0 means single.
- R9: A result from a source whose `cmp_en` bit is 0 produces no pulse and leaves both sticky flags unchanged.
- R10: `cmp_flag[s]` stays set until a cycle with `flag_clr[s]` = 1 clears it. If a hit and a clear for the same source arrive in the same cycle, the flag ends set.
- R11: A threshold write with `thr_we` takes effect at the next edge. A result sampled in the same cycle as the write is compared against the old thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 16 | Raw result, right-aligned |
| res_src | input | 1 | 0 = single, 1 = scan |
| res_diff | input | 1 | 1 = differential result |
| res_mode | input | 2 | Resolution code (see R2) |
| thr_we | input | 1 | Threshold write enable |
| thr_gt_wdata | input | 16 | New greater-than threshold |
| thr_lt_wdata | input | 16 | New less-than threshold |
| cmp_en | input | 2 | Per-source compare enable |
| flag_clr | input | 2 | Per-source write-1-to-clear |
| cmp_flag | output | 2 | Per-source sticky hit flag |
| cmp_pulse | output | 2 | Per-source one-cycle hit pulse |

## Verification
Some properties are checked by assertions on every cycle. A pulse may follow only a sampled result from an enabled source of the same index. A sticky flag may rise only together with its pulse, and it may fall only after a clear. The thresholds change only after a write. The arithmetic cannot be covered that way: sign extension versus zero padding, masking per resolution, signed versus unsigned ordering, and the strict boundaries in each window mode. Only the bench's vector table shows those, as do the same-cycle clear and threshold-write races.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  localparam int SRC_N = 2;
  localparam int SRC_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

  typedef enum logic [1:0] {
    RES_HI   = 2'd0,
    RES_MID  = 2'd1,
    RES_LO   = 2'd2,
    RES_FULL = 2'd3
  } res_mode_e;
endpackage

// File: rtl/cwc_norm.sv
module cwc_norm #(
  parameter int DATA_W = 16,
  parameter int W_HI   = 12,
  parameter int W_MID  = 8,
  parameter int W_LO   = 6
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              diff,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] norm
);
  import cwc_pkg::*;

  int unsigned width;
  logic        sign_bit;

  always_comb begin
    case (res_mode_e'(mode))
      RES_HI:  width = W_HI;
      RES_MID: width = W_MID;
      RES_LO:  width = W_LO;
      default: width = DATA_W;
    endcase
    sign_bit = diff & raw[width-1];
    for (int k = 0; k < DATA_W; k++) begin
      norm[k] = (k < width) ? raw[k] : sign_bit;
    end
  end
endmodule

// File: rtl/cwc_judge.sv
module cwc_judge #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] thr_gt,
  input  logic [DATA_W-1:0] thr_lt,
  input  logic              signed_cmp,
  output logic              hit
);
  logic above_gt, below_lt, inside_mode;

  always_comb begin
    if (signed_cmp) begin
      above_gt    = $signed(sample) > $signed(thr_gt);
      below_lt    = $signed(sample) < $signed(thr_lt);
      inside_mode = $signed(thr_lt) > $signed(thr_gt);
    end else begin
      above_gt    = sample > thr_gt;
      below_lt    = sample < thr_lt;
      inside_mode = thr_lt > thr_gt;
    end
    hit = inside_mode ? (above_gt & below_lt) : (above_gt | below_lt);
  end
endmodule

// File: rtl/cwc_flags.sv
module cwc_flags
  import cwc_pkg::*;
#(
  parameter int N = SRC_N,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [SW-1:0] src,
  input  logic [N-1:0]  en,
  input  logic [N-1:0]  clr,
  output logic [N-1:0]  pulse,
  output logic [N-1:0]  flag
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic sel;
    assign sel = fire && (src == SW'(i)) && en[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pulse[i] <= 1'b0;
        flag[i]  <= 1'b0;
      end else begin
        pulse[i] <= sel;
        if (sel)         flag[i] <= 1'b1;
        else if (clr[i]) flag[i] <= 1'b0;
      end
    end

    // R8
    pulse_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
      pulse[i] |-> $past(fire) && ($past(src) == SW'(i)));
    // R9
    pulse_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
      pulse[i] |-> $past(en[i]));
    // R10
    flag_rise_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flag[i]) |-> pulse[i]);
    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flag[i]) |-> $past(clr[i]));
  end
endmodule

// File: rtl/conv_window_cmp.sv
module conv_window_cmp
  import cwc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int W_HI   = 12,
  parameter int W_MID  = 8,
  parameter int W_LO   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [SRC_W-1:0]  res_src,
  input  logic              res_diff,
  input  logic [1:0]        res_mode,
  input  logic              thr_we,
  input  logic [DATA_W-1:0] thr_gt_wdata,
  input  logic [DATA_W-1:0] thr_lt_wdata,
  input  logic [SRC_N-1:0]  cmp_en,
  input  logic [SRC_N-1:0]  flag_clr,
  output logic [SRC_N-1:0]  cmp_flag,
  output logic [SRC_N-1:0]  cmp_pulse
);
  logic [DATA_W-1:0] gt_q, lt_q, sample;
  logic              hit, fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      gt_q <= '0;
      lt_q <= '0;
    end else if (thr_we) begin
      gt_q <= thr_gt_wdata;
      lt_q <= thr_lt_wdata;
    end
  end

  // R11
  thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(thr_we) |-> ($stable(gt_q) && $stable(lt_q)));

  cwc_norm #(.DATA_W(DATA_W), .W_HI(W_HI), .W_MID(W_MID), .W_LO(W_LO)) u_norm (
    .raw(res_data), .diff(res_diff), .mode(res_mode), .norm(sample)
  );

  cwc_judge #(.DATA_W(DATA_W)) u_judge (
    .sample(sample), .thr_gt(gt_q), .thr_lt(lt_q),
    .signed_cmp(res_diff), .hit(hit)
  );

  assign fire = res_valid & hit;

  cwc_flags #(.N(SRC_N)) u_flags (
    .clk(clk), .rst(rst), .fire(fire), .src(res_src), .en(cmp_en),
    .clr(flag_clr), .pulse(cmp_pulse), .flag(cmp_flag)
  );
endmodule

// File: tb/sim_conv_window_cmp.sv
`timescale 1ns/1ps
module sim_conv_window_cmp;
  logic        clk = 1'b0;
  logic        rst;
  logic        res_valid;
  logic [15:0] res_data;
  logic [0:0]  res_src;
  logic        res_diff;
  logic [1:0]  res_mode;
  logic        thr_we;
  logic [15:0] thr_gt_wdata, thr_lt_wdata;
  logic [1:0]  cmp_en, flag_clr;
  logic [1:0]  cmp_flag, cmp_pulse;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  conv_window_cmp u0 (.*);

  typedef struct packed {
    logic [15:0] gt;
    logic [15:0] lt;
    logic [15:0] data;
    logic        diff;
    logic [1:0]  mode;
    logic        src;
    logic        hit;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{16'd100, 16'd200, 16'd150, 1'b0, 2'd0, 1'b0, 1'b1},  // R5 inside
    '{16'd100, 16'd200, 16'd100, 1'b0, 2'd0, 1'b1, 1'b0},  // R5 low edge
    '{16'd100, 16'd200, 16'd200, 1'b0, 2'd0, 1'b0, 1'b0},  // R5 high edge
    '{16'd200, 16'd100, 16'd250, 1'b0, 2'd0, 1'b1, 1'b1},  // R6 above
    '{16'd200, 16'd100, 16'd150, 1'b0, 2'd0, 1'b0, 1'b0},  // R6 between
    '{16'd200, 16'd100, 16'd50,  1'b0, 2'd0, 1'b1, 1'b1},  // R6 below
    '{16'd200, 16'd100, 16'd200, 1'b0, 2'd0, 1'b0, 1'b0},  // R6 edge
    '{16'd50,  16'd50,  16'd50,  1'b0, 2'd0, 1'b1, 1'b0},  // R6 equal thr
    '{16'd50,  16'd50,  16'd51,  1'b0, 2'd0, 1'b0, 1'b1},  // R6 equal thr
    '{16'd3,   16'd10,  16'hFF05,1'b0, 2'd1, 1'b1, 1'b1},  // R2 8-bit mask
    '{16'h0040,16'h0100,16'hFFC0,1'b0, 2'd2, 1'b0, 1'b0},  // R2 6-bit mask -> 0
    '{16'h07FF,16'h0FFF,16'h0800,1'b0, 2'd0, 1'b1, 1'b1},  // R2 no sign ext
    '{16'hFFF0,16'h0005,16'h0FFF,1'b1, 2'd0, 1'b0, 1'b1},  // R3 R7 -1 inside
    '{16'hFFF0,16'h0005,16'h0FFF,1'b0, 2'd0, 1'b1, 1'b0},  // R7 unsigned
    '{16'hFFD8,16'hFFE2,16'h0020,1'b1, 2'd2, 1'b0, 1'b1},  // R3 6-bit -32
    '{16'hFFD8,16'hFFE2,16'h0080,1'b1, 2'd1, 1'b1, 1'b0},  // R3 8-bit -128
    '{16'h9000,16'h0100,16'h8000,1'b0, 2'd3, 1'b0, 1'b0},  // R4 full SE
    '{16'h9000,16'h0100,16'h8000,1'b0, 2'd0, 1'b1, 1'b1},  // R2 12-bit masks to 0
    '{16'h7000,16'h0100,16'h8000,1'b1, 2'd3, 1'b0, 1'b1}   // R4 full diff
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_thr(input logic [15:0] gt, input logic [15:0] lt);
    @(negedge clk);
    thr_we = 1'b1; thr_gt_wdata = gt; thr_lt_wdata = lt;
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  // drives one result for one cycle; returns at the negedge after the sampling edge
  task automatic send(input logic [15:0] d, input logic df, input logic [1:0] m, input logic s);
    @(negedge clk);
    res_valid = 1'b1; res_data = d; res_diff = df; res_mode = m; res_src = s;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    flag_clr = 2'b11;
    @(negedge clk);
    flag_clr = 2'b00;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; res_valid = 1'b0; res_data = '0; res_src = '0; res_diff = 1'b0;
    res_mode = 2'd0; thr_we = 1'b0; thr_gt_wdata = '0; thr_lt_wdata = '0;
    cmp_en = 2'b11; flag_clr = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 flags", 32'(cmp_flag), 32'd0);
    check("R1 pulses", 32'(cmp_pulse), 32'd0);
    send(16'd0, 1'b0, 2'd0, 1'b0);
    check("R1 zero thr, sample 0", 32'(cmp_pulse), 32'd0);
    send(16'd1, 1'b0, 2'd0, 1'b0);
    check("R1 zero thr, sample 1", 32'(cmp_pulse), 32'd1);

    for (int v = 0; v < NV; v++) begin
      clear_all();
      wr_thr(VECS[v].gt, VECS[v].lt);
      send(VECS[v].data, VECS[v].diff, VECS[v].mode, VECS[v].src);
      check($sformatf("R5/R6 vector %0d pulse", v), 32'(cmp_pulse),
            VECS[v].hit ? (32'd1 << VECS[v].src) : 32'd0);
      check($sformatf("R10 vector %0d flag", v), 32'(cmp_flag),
            VECS[v].hit ? (32'd1 << VECS[v].src) : 32'd0);
    end

    // R8: pulse lasts one cycle
    clear_all();
    wr_thr(16'd100, 16'd200);
    send(16'd150, 1'b0, 2'd0, 1'b1);
    check("R8 pulse present", 32'(cmp_pulse), 32'd2);
    @(negedge clk);
    check("R8 pulse gone", 32'(cmp_pulse), 32'd0);
    check("R10 flag sticky", 32'(cmp_flag), 32'd2);
    send(16'd10, 1'b0, 2'd0, 1'b1);
    check("R10 flag kept on miss", 32'(cmp_flag), 32'd2);

    // R9: disabled single source
    clear_all();
    cmp_en = 2'b10;
    send(16'd150, 1'b0, 2'd0, 1'b0);
    check("R9 disabled pulse", 32'(cmp_pulse), 32'd0);
    check("R9 disabled flag", 32'(cmp_flag), 32'd0);
    send(16'd150, 1'b0, 2'd0, 1'b1);
    check("R9 enabled scan still hits", 32'(cmp_pulse), 32'd2);
    cmp_en = 2'b11;

    // R10: clear, and hit plus clear in the same cycle
    clear_all();
    check("R10 w1c", 32'(cmp_flag), 32'd0);
    @(negedge clk);
    res_valid = 1'b1; res_data = 16'd150; res_diff = 1'b0; res_mode = 2'd0; res_src = 1'b0;
    flag_clr = 2'b01;
    @(negedge clk);
    res_valid = 1'b0; flag_clr = 2'b00;
    check("R10 set wins over clear", 32'(cmp_flag), 32'd1);

    // R11: result sampled with a threshold write uses old thresholds
    clear_all();
    @(negedge clk);
    thr_we = 1'b1; thr_gt_wdata = 16'd300; thr_lt_wdata = 16'd400;
    res_valid = 1'b1; res_data = 16'd150; res_src = 1'b0;
    @(negedge clk);
    thr_we = 1'b0; res_valid = 1'b0;
    check("R11 old thresholds used", 32'(cmp_pulse), 32'd1);
    send(16'd150, 1'b0, 2'd0, 1'b0);
    check("R11 new thresholds used", 32'(cmp_pulse), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule